// File: doc/BRIEF.md
# Multi-Master Crossbar Arbiter

This block is a small switch between four bus masters and three target ports, clocked with the masters. Master 0 is the processor. The others may be a DMA engine, a USB controller or a debug port. The targets may be SRAM, flash or a bridge to slower peripherals. Each master presents a request, an address, a write strobe and write data. It holds them until it sees completion. Each target answers a granted transfer with a one-cycle done pulse and its read data.

Every target has its own arbiter. Masters that address different targets therefore get independent point-to-point paths in the same cycle. When several masters want one target, that target's arbiter picks a winner. The winner keeps the path until the target signals done, and the losers wait.

A configuration register selects the arbitration scheme and the master that heads the fixed orders. The schemes are:
- plain fixed priority;
- fixed priority with the processor pushed to the bottom;
- rotating priority.

Top module: `xbar_arb`

## Requirements
- R1: While reset is low, and in the first cycle after it, no master is granted, no target sees a request and every `m_done` and `m_rdata` bit is zero.
- R2: A master's target is chosen by the top two address bits. Value 0 selects target 0 and value 1 selects target 1. Values 2 and 3 both select target 2.
- R3: Requests to different targets are granted at the same clock edge. A request present before an edge on a free target is granted from that edge.
- R4: A target holds at most one grant. The grant stays with the same master until that target's `t_done` is high at an edge, whatever other masters request meanwhile.
- R5: With `cfg_mode` 0 (and also with 3), priority is fixed. It runs from master `cfg_top` upward, wrapping modulo 4.
- R6: With `cfg_mode` 1, masters 1 to 3 are ordered upward from `cfg_top`, skipping master 0. Master 0 wins only when no other master requests that target.
- R7: With `cfg_mode` 2, each target starts its search at the master after the one it granted most recently. That per-target record is updated by every grant in any mode, and after reset it points at master 3.
- R8: `cfg_mode` and `cfg_top` are loaded at an edge where `cfg_we` is high. An arbitration decision made at that same edge still uses the previous values.
- R9: A target's `t_addr`, `t_we` and `t_wdata` come from its granted master. That master's `m_rdata` shows the target's `t_rdata`, and its `m_done` mirrors `t_done`. An ungranted master sees zero on both.
- R10: After the edge that ends a transfer, the target stays free for one cycle. A waiting request is granted at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with all masters |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads the configuration fields |
| cfg_mode | input | 2 | Scheme: 0 fixed, 1 processor lowest, 2 rotating, 3 fixed |
| cfg_top | input | 2 | Master heading the fixed orders |
| m_req | input | 4 | Request per master |
| m_we | input | 4 | Write strobe per master |
| m_addr | input | 64 | Address per master, 16 bits each |
| m_wdata | input | 128 | Write data per master, 32 bits each |
| m_gnt | output | 4 | Path granted per master |
| m_done | output | 4 | Transfer completion per master |
| m_rdata | output | 128 | Read data per master |
| t_req | output | 3 | Transfer active per target |
| t_we | output | 3 | Write strobe per target |
| t_addr | output | 48 | Address per target |
| t_wdata | output | 96 | Write data per target |
| t_done | input | 3 | Completion pulse per target |
| t_rdata | input | 96 | Read data per target |

## Verification
The bench builds the block with its default parameters: four masters, three targets, 16-bit addresses and 32-bit data. With four masters, all three schemes can be driven with every master contending at once. A full turn of the rotating order fits in four transfers. Two masters can also land on target 2 through the two address codes that both map there. Three targets are enough to show all parallel paths open in one cycle, next to a contended target that resolves separately.

// File: rtl/xbar_arb.sv
module xbar_arb #(
  parameter int N_M = 4,
  parameter int N_T = 3,
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int CPU = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_mode,
  input  logic [$clog2(N_M)-1:0] cfg_top,
  input  logic [N_M-1:0]         m_req,
  input  logic [N_M-1:0]         m_we,
  input  logic [N_M*AW-1:0]      m_addr,
  input  logic [N_M*DW-1:0]      m_wdata,
  output logic [N_M-1:0]         m_gnt,
  output logic [N_M-1:0]         m_done,
  output logic [N_M*DW-1:0]      m_rdata,
  output logic [N_T-1:0]         t_req,
  output logic [N_T-1:0]         t_we,
  output logic [N_T*AW-1:0]      t_addr,
  output logic [N_T*DW-1:0]      t_wdata,
  input  logic [N_T-1:0]         t_done,
  input  logic [N_T*DW-1:0]      t_rdata
);
  localparam int MIW = $clog2(N_M);
  localparam int TSW = (N_T > 1) ? $clog2(N_T) : 1;

  logic [1:0]                mode_q;
  logic [MIW-1:0]            top_q;
  logic [N_T-1:0]            busy;
  logic [N_T-1:0][MIW-1:0]   own;
  logic [N_T-1:0][MIW-1:0]   last;
  logic [N_M-1:0][TSW-1:0]   msel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      top_q  <= '0;
    end else if (cfg_we) begin
      mode_q <= cfg_mode;
      top_q  <= cfg_top;
    end
  end

  function automatic logic [MIW:0] pick(input logic [N_M-1:0] rq,
                                        input logic [MIW-1:0] start,
                                        input logic cpu_last);
    logic [MIW:0] r;
    r = '0;
    for (int k = N_M - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(start) + k) % N_M;
      if (rq[idx] && !(cpu_last && idx == CPU)) r = {1'b1, MIW'(idx)};
    end
    if (!r[MIW] && cpu_last && rq[CPU]) r = {1'b1, MIW'(CPU)};
    return r;
  endfunction

  for (genvar m = 0; m < N_M; m++) begin : g_dec
    logic [TSW-1:0] hi;
    assign hi      = m_addr[m*AW+AW-1 -: TSW];
    assign msel[m] = (int'(hi) >= N_T) ? TSW'(N_T - 1) : hi;
  end

  for (genvar t = 0; t < N_T; t++) begin : g_tgt
    logic [N_M-1:0] rq;
    logic [MIW-1:0] start;
    logic [MIW:0]   win;

    for (genvar m = 0; m < N_M; m++) begin : g_rq
      assign rq[m] = m_req[m] && (int'(msel[m]) == t);
    end

    assign start = (mode_q == 2'd2) ? MIW'((int'(last[t]) + 1) % N_M) : top_q;
    assign win   = pick(rq, start, mode_q == 2'd1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[t] <= 1'b0;
        own[t]  <= '0;
        last[t] <= MIW'(N_M - 1);
      end else if (busy[t]) begin
        if (t_done[t]) busy[t] <= 1'b0;
      end else if (win[MIW]) begin
        busy[t] <= 1'b1;
        own[t]  <= win[MIW-1:0];
        last[t] <= win[MIW-1:0];
      end
    end

    assign t_req[t]              = busy[t];
    assign t_we[t]               = busy[t] && m_we[own[t]];
    assign t_addr[t*AW +: AW]    = busy[t] ? m_addr[own[t]*AW +: AW] : '0;
    assign t_wdata[t*DW +: DW]   = busy[t] ? m_wdata[own[t]*DW +: DW] : '0;
  end

  always_comb begin
    m_gnt   = '0;
    m_done  = '0;
    m_rdata = '0;
    for (int t = 0; t < N_T; t++) begin
      if (busy[t]) begin
        m_gnt[own[t]]               = 1'b1;
        m_done[own[t]]              = t_done[t];
        m_rdata[own[t]*DW +: DW]    = t_rdata[t*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/xbar_arb_chk.sv
module xbar_arb_chk #(
  parameter int N_M = 4,
  parameter int N_T = 3,
  parameter int MIW = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_we,
  input logic [1:0]             mode_q,
  input logic [MIW-1:0]         top_q,
  input logic [N_M-1:0]         m_req,
  input logic [N_M-1:0]         m_gnt,
  input logic [N_T-1:0]         t_req,
  input logic [N_T-1:0]         t_done,
  input logic [N_T-1:0]         busy,
  input logic [N_T-1:0][MIW-1:0] own
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (m_gnt == '0 && t_req == '0));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(mode_q) && $stable(top_q)));

  for (genvar t = 0; t < N_T; t++) begin : g_t
    // R4
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[t] && !t_done[t]) |=> (busy[t] && $stable(own[t])));
    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (t_req[t] && t_done[t]) |=> !t_req[t]);
    // R9
    owner_sees_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t_req[t] |-> m_gnt[own[t]]);
  end

  for (genvar m = 0; m < N_M; m++) begin : g_m
    // R3
    gnt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_gnt[m]) |-> $past(m_req[m]));
  end
endmodule

bind xbar_arb xbar_arb_chk #(.N_M(N_M), .N_T(N_T), .MIW(MIW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .mode_q(mode_q), .top_q(top_q),
  .m_req(m_req), .m_gnt(m_gnt), .t_req(t_req), .t_done(t_done),
  .busy(busy), .own(own)
);

// File: tb/sim_xbar_arb.sv
`timescale 1ns/1ps
module sim_xbar_arb;
  localparam int N_M = 4, N_T = 3, AW = 16, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = '0, cfg_top = '0;
  logic [N_M-1:0] m_req = '0, m_we = '0;
  logic [N_M*AW-1:0] m_addr = '0;
  logic [N_M*DW-1:0] m_wdata;
  logic [N_M-1:0] m_gnt, m_done;
  logic [N_M*DW-1:0] m_rdata;
  logic [N_T-1:0] t_req, t_we;
  logic [N_T*AW-1:0] t_addr;
  logic [N_T*DW-1:0] t_wdata;
  logic [N_T-1:0] t_done = '0;
  logic [N_T*DW-1:0] t_rdata;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  for (genvar m = 0; m < N_M; m++) begin : g_wd
    assign m_wdata[m*DW +: DW] = 32'hC0DE_0000 | m;
  end
  for (genvar t = 0; t < N_T; t++) begin : g_rd
    assign t_rdata[t*DW +: DW] = 32'hA5A5_0000 | t;
  end

  xbar_arb u0 (.*);

  // {mode, top, req[3:0], sel m3..m0 (2 bits each), expected grant}
  localparam logic [19:0] VEC [12] = '{
    {2'd0, 2'd0, 4'b1111, 8'h00, 4'b0001},
    {2'd0, 2'd2, 4'b1111, 8'h00, 4'b0100},
    {2'd1, 2'd0, 4'b1111, 8'h00, 4'b0010},
    {2'd1, 2'd0, 4'b0001, 8'h00, 4'b0001},
    {2'd0, 2'd0, 4'b1111, 8'hE4, 4'b0111},
    {2'd2, 2'd0, 4'b1111, 8'h00, 4'b0010},
    {2'd2, 2'd0, 4'b1111, 8'h00, 4'b0100},
    {2'd2, 2'd0, 4'b1111, 8'h00, 4'b1000},
    {2'd2, 2'd0, 4'b1111, 8'h00, 4'b0001},
    {2'd2, 2'd0, 4'b0101, 8'h00, 4'b0100},
    {2'd1, 2'd3, 4'b1111, 8'h55, 4'b1000},
    {2'd0, 2'd1, 4'b1001, 8'hC2, 4'b1000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_addr(input int m, input logic [1:0] sel);
    m_addr[m*AW +: AW] = {sel, 14'(m * 16 + 5)};
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(); step();
    chk("R1 reset grants", 64'(m_gnt), 0);
    chk("R1 reset target req", 64'(t_req), 0);
    chk("R1 reset done/rdata", 64'({m_done, m_rdata}), 0);
    rst_n = 1'b1;
    chk("R1 first cycle after reset", 64'({m_gnt, t_req}), 0);

    // R9 / R2 routing: master 1 writes to target 1
    set_addr(1, 2'd1); m_we = 4'b0010; m_req = 4'b0010;
    step();
    chk("R2 target select", 64'(t_req), 64'b010);
    chk("R9 t_addr", 64'(t_addr[AW +: AW]), 64'({2'd1, 14'(21)}));
    chk("R9 t_we", 64'(t_we), 64'b010);
    chk("R9 t_wdata", 64'(t_wdata[DW +: DW]), 64'h0000_0000_C0DE_0001);
    chk("R9 m_rdata owner", 64'(m_rdata[DW +: DW]), 64'h0000_0000_A5A5_0001);
    chk("R9 m_rdata other", 64'(m_rdata[0 +: DW]), 0);
    t_done = 3'b010; m_req = '0; m_we = '0; #1;
    chk("R9 m_done mirror", 64'(m_done), 64'b0010);
    step(); t_done = '0;

    for (int v = 0; v < 12; v++) begin
      logic [19:0] e;
      e = VEC[v];
      cfg_we = 1'b1; cfg_mode = e[19:18]; cfg_top = e[17:16];
      step();
      cfg_we = 1'b0;
      for (int m = 0; m < N_M; m++) set_addr(m, e[4 + 2*m +: 2]);
      m_req = e[15:12];
      step();
      chk($sformatf("R5 R6 R7 R3 vector %0d grant", v), 64'(m_gnt), 64'(e[3:0]));
      step();
      chk($sformatf("R4 vector %0d held", v), 64'(m_gnt), 64'(e[3:0]));
      t_done = '1; m_req = '0; #1;
      chk($sformatf("R9 vector %0d done", v), 64'(m_done), 64'(e[3:0]));
      step();
      t_done = '0;
      chk($sformatf("R10 vector %0d released", v), 64'(m_gnt), 0);
    end

    // R8: write new top together with contending requests; old top=1 decides
    for (int m = 0; m < N_M; m++) set_addr(m, 2'd0);
    cfg_we = 1'b1; cfg_mode = 2'd0; cfg_top = 2'd0; m_req = 4'b0101;
    step();
    cfg_we = 1'b0;
    chk("R8 decision uses old config", 64'(m_gnt), 64'b0100);
    t_done = '1; m_req = '0; step(); t_done = '0;
    m_req = 4'b0101; step();
    chk("R8 new config after write", 64'(m_gnt), 64'b0001);
    t_done = '1; m_req = '0; step(); t_done = '0;

    // R4 / R10: hold against a higher-priority newcomer, then idle cycle
    m_req = 4'b0100; step();
    chk("R4 lone request granted", 64'(m_gnt), 64'b0100);
    m_req = 4'b0101;
    step(); step(); step();
    chk("R4 grant kept while done low", 64'(m_gnt), 64'b0100);
    chk("R4 no done yet", 64'(m_done), 0);
    t_done = 3'b001; m_req = 4'b0001; #1;
    chk("R9 done to owner only", 64'(m_done), 64'b0100);
    step(); t_done = '0;
    chk("R10 free cycle", 64'(m_gnt), 0);
    step();
    chk("R10 waiter granted next", 64'(m_gnt), 64'b0001);
    t_done = '1; m_req = '0; step(); t_done = '0;

    // R5: mode 3 behaves as fixed priority
    cfg_we = 1'b1; cfg_mode = 2'd3; cfg_top = 2'd1; step(); cfg_we = 1'b0;
    for (int m = 0; m < N_M; m++) set_addr(m, 2'd1);
    m_req = 4'b1111; step();
    chk("R5 mode 3 fixed", 64'(m_gnt), 64'b0010);

    // R1: reset while a path is held
    rst_n = 1'b0; step();
    chk("R1 reset drops held path", 64'({m_gnt, t_req}), 0);
    m_req = '0; rst_n = 1'b1; step();

    finish_run();
  end
endmodule